// File: doc/BRIEF.md
# Tiered write-once lock controller

This block holds the protected configuration fields of a timer output stage and decides, write by write, which of them may still change. The fields are a dead-time code, the output idle levels, the break enable and break polarity, automatic output enable, the off-state select bits for run and idle, the channel polarity bits, and the per-channel compare mode and preload enable. Software writes through a simple request: `wr_en` with a select code and a data word. The stored values drive the timer datapath directly.

A two-bit protection level sets what is frozen. Each level keeps everything the level below it froze and adds more. The level sits in the same register group as the dead-time code. It takes only the first write to that group after reset; after that the level holds until the next reset. A small state machine tracks this. Its states are `ST_OPEN` (never written, level 0) and `ST_SEAL_L0` to `ST_SEAL_L3` (level fixed at 0 to 3). Its one transition is `ST_OPEN -> ST_SEAL_Ln`, taken on the first write with select 0, with n taken from data bits 14:13. Every sealed state holds itself until reset. Polarity, compare-mode and preload bits are protected per channel, and only while the channel's `ch_is_out` flag is high in the cycle of the write.

Top module: `tiered_lock_ctl`

## Requirements
- R1: After reset every stored field is 0 and `lock_lvl` is 0.
- R2: The first write with select 0 after reset loads `lock_lvl` from data bits 14:13, one clock after the write. Later writes never change it. The other fields in that sealing write are judged against the level from before the write.
- R3: The sealing write counts even when it writes level 0, so a later attempt to raise the level is ignored.
- R4: At level 0 every field is writable, and each takes its value one clock after the write. Select 0 carries the dead-time code in bits 7:0, break enable in bit 8, break polarity in bit 9, automatic output enable in bit 10, off-state idle in bit 11, off-state run in bit 12 and the level in bits 14:13. Select 1 carries idle levels in bits 2*NCH-1:0. Select 2 carries channel c's polarity pair in bits 2c+1:2c. Select 3 carries channel c's compare mode in bits 4c+2:4c and its preload enable in bit 4c+3.
- R5: At any nonzero level the dead-time code cannot change.
- R6: At any nonzero level the idle levels, break enable, break polarity and automatic output enable cannot change.
- R7: At level 2 or 3 the off-state run and idle bits cannot change.
- R8: At level 2 or 3 a channel's polarity pair cannot change while that channel is an output. It stays writable while the channel is an input.
- R9: At level 3 a channel's compare mode and preload bit cannot change while that channel is an output. They stay writable at lower levels or while the channel is an input.
- R10: A write that touches both frozen and open fields updates the open ones and silently leaves the frozen ones unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request strobe |
| wr_sel | input | 2 | Register group select (0 to 3) |
| wr_data | input | DATA_W | Write data word |
| ch_is_out | input | NCH | Per-channel output direction flag |
| dt_code | output | 8 | Stored dead-time code |
| idle_lvl | output | 2*NCH | Stored idle levels, main and complementary per channel |
| brk_en | output | 1 | Stored break enable |
| brk_pol | output | 1 | Stored break polarity |
| auto_oe | output | 1 | Stored automatic output enable |
| ofs_run | output | 1 | Stored off-state select, run mode |
| ofs_idle | output | 1 | Stored off-state select, idle mode |
| ch_pol | output | 2*NCH | Stored polarity pairs |
| oc_mode | output | 3*NCH | Stored compare mode, 3 bits per channel |
| oc_pre | output | NCH | Stored preload enable per channel |
| lock_lvl | output | 2 | Current protection level |

## Verification
The bench runs every protection level against every channel direction pattern and writes every register group with changing data. It compares each field with a model. A design that checked the new level instead of the old one in the sealing write would freeze fields early and fail R2. A design that let a level-0 seal be rewritten would report level 3 and fail R3. A design that ignored direction, or chose the wrong level threshold for polarity or compare mode, would freeze input channels or leave output channels open, and the mixed-direction runs expose both. Mixed writes at level 1 show whether a frozen field blocks its open neighbours in the same word.

// File: rtl/tlock_pkg.sv
package tlock_pkg;

    typedef enum logic [1:0] {
        SEL_PROT = 2'd0,
        SEL_IDLE = 2'd1,
        SEL_POL  = 2'd2,
        SEL_OCM  = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_OPEN    = 3'd0,
        ST_SEAL_L0 = 3'd1,
        ST_SEAL_L1 = 3'd2,
        ST_SEAL_L2 = 3'd3,
        ST_SEAL_L3 = 3'd4
    } lock_st_e;

    localparam int DT_W         = 8;
    localparam int DT_LSB       = 0;
    localparam int BRK_EN_BIT   = 8;
    localparam int BRK_POL_BIT  = 9;
    localparam int AOE_BIT      = 10;
    localparam int OFS_IDLE_BIT = 11;
    localparam int OFS_RUN_BIT  = 12;
    localparam int LOCK_LSB     = 13;
    localparam int PROT_TOP     = LOCK_LSB + 2;
    localparam int OCM_MODE_W   = 3;
    localparam int OCM_SLOT_W   = OCM_MODE_W + 1;

    typedef struct packed {
        logic dt_ok;
        logic tier1_ok;
        logic ofs_ok;
    } glob_perm_t;

endpackage

// File: rtl/tlock_fsm.sv
module tlock_fsm
    import tlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [1:0] lock_req,
    output logic [1:0] lock_lvl
);

    lock_st_e st_q;
    lock_st_e st_nxt;
    logic     seal_req;

    assign seal_req = wr_en && (sel_e'(wr_sel) == SEL_PROT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OPEN;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_OPEN: begin
                if (seal_req) begin
                    unique case (lock_req)
                        2'd0: st_nxt = ST_SEAL_L0;
                        2'd1: st_nxt = ST_SEAL_L1;
                        2'd2: st_nxt = ST_SEAL_L2;
                        2'd3: st_nxt = ST_SEAL_L3;
                        default: st_nxt = ST_OPEN;
                    endcase
                end
            end
            ST_SEAL_L0, ST_SEAL_L1, ST_SEAL_L2, ST_SEAL_L3: st_nxt = st_q;
            default: st_nxt = ST_OPEN;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_OPEN:    lock_lvl = 2'd0;
            ST_SEAL_L0: lock_lvl = 2'd0;
            ST_SEAL_L1: lock_lvl = 2'd1;
            ST_SEAL_L2: lock_lvl = 2'd2;
            ST_SEAL_L3: lock_lvl = 2'd3;
            default:    lock_lvl = 2'd0;
        endcase
    end

    // R2: once sealed the level never moves
    assert_level_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OPEN) |=> (lock_lvl == $past(lock_lvl)));

    // R3: any first group-0 write seals, whatever level it carries
    assert_first_write_seals_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && seal_req) |=> (st_q != ST_OPEN));

    // R2: the sealed level is the requested one
    assert_seal_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && seal_req) |=> (lock_lvl == $past(lock_req)));

endmodule

// File: rtl/tlock_perm.sv
module tlock_perm
    import tlock_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic [1:0]     lock_lvl,
    input  logic [NCH-1:0] ch_is_out,
    output glob_perm_t     gperm,
    output logic [NCH-1:0] pol_ok,
    output logic [NCH-1:0] ocm_ok
);

    logic lvl_zero;
    logic lvl_below2;
    logic lvl_top;

    assign lvl_zero   = (lock_lvl == 2'd0);
    assign lvl_below2 = (lock_lvl < 2'd2);
    assign lvl_top    = (lock_lvl == 2'd3);

    always_comb begin
        gperm.dt_ok    = lvl_zero;
        gperm.tier1_ok = lvl_zero;
        gperm.ofs_ok   = lvl_below2;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch_perm
        assign pol_ok[c] = lvl_below2 || !ch_is_out[c];
        assign ocm_ok[c] = !lvl_top   || !ch_is_out[c];
    end

endmodule

// File: rtl/tlock_store.sv
module tlock_store
    import tlock_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DATA_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [1:0]               lock_lvl,
    input  logic [NCH-1:0]           ch_is_out,
    input  glob_perm_t               gperm,
    input  logic [NCH-1:0]           pol_ok,
    input  logic [NCH-1:0]           ocm_ok,
    output logic [DT_W-1:0]          dt_code,
    output logic [2*NCH-1:0]         idle_lvl,
    output logic                     brk_en,
    output logic                     brk_pol,
    output logic                     auto_oe,
    output logic                     ofs_run,
    output logic                     ofs_idle,
    output logic [2*NCH-1:0]         ch_pol,
    output logic [OCM_MODE_W*NCH-1:0] oc_mode,
    output logic [NCH-1:0]           oc_pre
);

    localparam int IDLE_W = 2 * NCH;

    logic wr_prot;
    logic wr_idle;
    logic wr_pol;
    logic wr_ocm;

    always_comb begin
        wr_prot = 1'b0;
        wr_idle = 1'b0;
        wr_pol  = 1'b0;
        wr_ocm  = 1'b0;
        if (wr_en) begin
            unique case (sel_e'(wr_sel))
                SEL_PROT: wr_prot = 1'b1;
                SEL_IDLE: wr_idle = 1'b1;
                SEL_POL:  wr_pol  = 1'b1;
                SEL_OCM:  wr_ocm  = 1'b1;
                default:  wr_prot = 1'b0;
            endcase
        end
    end

    // group 0: dead time, break controls, off-state selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_code  <= '0;
            brk_en   <= 1'b0;
            brk_pol  <= 1'b0;
            auto_oe  <= 1'b0;
            ofs_run  <= 1'b0;
            ofs_idle <= 1'b0;
        end else if (wr_prot) begin
            if (gperm.dt_ok) begin
                dt_code <= wr_data[DT_LSB +: DT_W];
            end
            if (gperm.tier1_ok) begin
                brk_en  <= wr_data[BRK_EN_BIT];
                brk_pol <= wr_data[BRK_POL_BIT];
                auto_oe <= wr_data[AOE_BIT];
            end
            if (gperm.ofs_ok) begin
                ofs_run  <= wr_data[OFS_RUN_BIT];
                ofs_idle <= wr_data[OFS_IDLE_BIT];
            end
        end
    end

    // group 1: idle levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_lvl <= '0;
        end else if (wr_idle && gperm.tier1_ok) begin
            idle_lvl <= wr_data[IDLE_W-1:0];
        end
    end

    // groups 2 and 3: per-channel slots
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_pol[2*c +: 2] <= 2'b00;
            end else if (wr_pol && pol_ok[c]) begin
                ch_pol[2*c +: 2] <= wr_data[2*c +: 2];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oc_mode[OCM_MODE_W*c +: OCM_MODE_W] <= '0;
                oc_pre[c]                           <= 1'b0;
            end else if (wr_ocm && ocm_ok[c]) begin
                oc_mode[OCM_MODE_W*c +: OCM_MODE_W] <= wr_data[OCM_SLOT_W*c +: OCM_MODE_W];
                oc_pre[c]                           <= wr_data[OCM_SLOT_W*c + OCM_MODE_W];
            end
        end

        // R8: polarity of an output channel is frozen from level 2
        assert_pol_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_lvl >= 2'd2 && ch_is_out[c]) |=> $stable(ch_pol[2*c +: 2]));

        // R9: compare mode and preload of an output channel frozen at level 3
        assert_ocm_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_lvl == 2'd3 && ch_is_out[c]) |=>
                ($stable(oc_mode[OCM_MODE_W*c +: OCM_MODE_W]) && $stable(oc_pre[c])));

        // R8: an input channel's polarity still follows a write at level 3
        assert_pol_input_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_pol && !ch_is_out[c]) |=> (ch_pol[2*c +: 2] == $past(wr_data[2*c +: 2])));
    end

    // R5: dead-time code frozen at any nonzero level
    assert_dt_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != 2'd0) |=> $stable(dt_code));

    // R6: tier-one controls frozen at any nonzero level
    assert_tier1_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != 2'd0) |=>
            ($stable(idle_lvl) && $stable(brk_en) && $stable(brk_pol) && $stable(auto_oe)));

    // R7: off-state selects frozen from level 2
    assert_ofs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl >= 2'd2) |=> ($stable(ofs_run) && $stable(ofs_idle)));

    // R10: at level 1 a group-0 write still lands its open fields
    assert_partial_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl == 2'd1 && wr_prot) |=>
            (ofs_run == $past(wr_data[OFS_RUN_BIT]) && ofs_idle == $past(wr_data[OFS_IDLE_BIT])));

endmodule

// File: rtl/tiered_lock_ctl.sv
module tiered_lock_ctl
    import tlock_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DATA_W = (OCM_SLOT_W * NCH > PROT_TOP) ? OCM_SLOT_W * NCH : PROT_TOP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NCH-1:0]           ch_is_out,
    output logic [DT_W-1:0]          dt_code,
    output logic [2*NCH-1:0]         idle_lvl,
    output logic                     brk_en,
    output logic                     brk_pol,
    output logic                     auto_oe,
    output logic                     ofs_run,
    output logic                     ofs_idle,
    output logic [2*NCH-1:0]         ch_pol,
    output logic [OCM_MODE_W*NCH-1:0] oc_mode,
    output logic [NCH-1:0]           oc_pre,
    output logic [1:0]               lock_lvl
);

    glob_perm_t     gperm;
    logic [NCH-1:0] pol_ok;
    logic [NCH-1:0] ocm_ok;

    tlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .lock_req (wr_data[LOCK_LSB +: 2]),
        .lock_lvl (lock_lvl)
    );

    tlock_perm #(.NCH(NCH)) u_perm (
        .lock_lvl  (lock_lvl),
        .ch_is_out (ch_is_out),
        .gperm     (gperm),
        .pol_ok    (pol_ok),
        .ocm_ok    (ocm_ok)
    );

    tlock_store #(.NCH(NCH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .lock_lvl  (lock_lvl),
        .ch_is_out (ch_is_out),
        .gperm     (gperm),
        .pol_ok    (pol_ok),
        .ocm_ok    (ocm_ok),
        .dt_code   (dt_code),
        .idle_lvl  (idle_lvl),
        .brk_en    (brk_en),
        .brk_pol   (brk_pol),
        .auto_oe   (auto_oe),
        .ofs_run   (ofs_run),
        .ofs_idle  (ofs_idle),
        .ch_pol    (ch_pol),
        .oc_mode   (oc_mode),
        .oc_pre    (oc_pre)
    );

endmodule

// File: tb/tiered_lock_ctl_test.sv
`timescale 1ns/1ps
module tiered_lock_ctl_test;

    localparam int NCH = 2;
    localparam int DW  = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'd0;
    logic [DW-1:0]   wr_data = '0;
    logic [NCH-1:0]  ch_is_out = '0;
    logic [7:0]      dt_code;
    logic [3:0]      idle_lvl;
    logic            brk_en, brk_pol, auto_oe, ofs_run, ofs_idle;
    logic [3:0]      ch_pol;
    logic [5:0]      oc_mode;
    logic [1:0]      oc_pre;
    logic [1:0]      lock_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model
    logic [7:0] m_dt;
    logic [3:0] m_idle, m_pol;
    logic [2:0] m_brk;
    logic [1:0] m_ofs, m_lvl, m_pre;
    logic [5:0] m_mode;
    bit         m_sealed;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    tiered_lock_ctl #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ch_is_out(ch_is_out), .dt_code(dt_code),
        .idle_lvl(idle_lvl), .brk_en(brk_en), .brk_pol(brk_pol),
        .auto_oe(auto_oe), .ofs_run(ofs_run), .ofs_idle(ofs_idle),
        .ch_pol(ch_pol), .oc_mode(oc_mode), .oc_pre(oc_pre), .lock_lvl(lock_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h lvl=%0d dir=%b", tag, act, exp, m_lvl, ch_is_out);
        end
    endtask

    function automatic string ftag(input string locked_tag, input bit open);
        return open ? "R4" : locked_tag;
    endfunction

    task automatic check_all();
        chk("R2 lock_lvl", {30'd0, lock_lvl}, {30'd0, m_lvl});
        chk(ftag("R5 dt_code", m_lvl == 0), {24'd0, dt_code}, {24'd0, m_dt});
        chk(ftag("R6 break/aoe", m_lvl == 0), {29'd0, auto_oe, brk_pol, brk_en}, {29'd0, m_brk});
        chk(ftag("R6 idle_lvl", m_lvl == 0), {28'd0, idle_lvl}, {28'd0, m_idle});
        chk(ftag("R7 ofs", m_lvl < 2), {30'd0, ofs_run, ofs_idle}, {30'd0, m_ofs});
        chk(ftag("R8 ch_pol", m_lvl < 2), {28'd0, ch_pol}, {28'd0, m_pol});
        chk(ftag("R9 oc_mode/pre", m_lvl < 3), {24'd0, oc_pre, oc_mode}, {24'd0, m_pre, m_mode});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_dt = '0; m_idle = '0; m_pol = '0; m_brk = '0; m_ofs = '0;
        m_lvl = '0; m_pre = '0; m_mode = '0; m_sealed = 1'b0;
        chk("R1 reset lock_lvl", {30'd0, lock_lvl}, 32'd0);
        chk("R1 reset fields", {dt_code, idle_lvl, brk_en, brk_pol, auto_oe, ofs_run, ofs_idle},
            32'd0);
        chk("R1 reset channels", {ch_pol, oc_mode, oc_pre}, 32'd0);
    endtask

    task automatic model_write(input logic [1:0] sel, input logic [DW-1:0] d);
        case (sel)
            2'd0: begin
                if (m_lvl == 0) begin
                    m_dt  = d[7:0];
                    m_brk = {d[10], d[9], d[8]};
                end
                if (m_lvl < 2) m_ofs = {d[12], d[11]};
                if (!m_sealed) begin
                    m_lvl = d[14:13];
                    m_sealed = 1'b1;
                end
            end
            2'd1: if (m_lvl == 0) m_idle = d[3:0];
            2'd2: for (int c = 0; c < NCH; c++)
                    if (m_lvl < 2 || !ch_is_out[c]) m_pol[2*c +: 2] = d[2*c +: 2];
            default: for (int c = 0; c < NCH; c++)
                    if (m_lvl != 3 || !ch_is_out[c]) begin
                        m_mode[3*c +: 3] = d[4*c +: 3];
                        m_pre[c] = d[4*c + 3];
                    end
        endcase
    endtask

    // drives on negedge, registers update at next posedge, checks at following negedge
    task automatic do_write(input logic [1:0] sel, input logic [DW-1:0] d);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(sel, d);
        check_all();
    endtask

    function automatic logic [DW-1:0] next_pat();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[DW+7:8];
    endfunction

    initial begin
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int dir = 0; dir < 4; dir++) begin
                ch_is_out = dir[1:0];
                do_reset();
                // R4: everything open before sealing, incl. channel groups
                for (int s = 1; s < 4; s++) do_write(s[1:0], next_pat());
                // R2: sealing write, other fields judged at level 0
                do_write(2'd0, {lvl[1:0], next_pat()[12:0]});
                for (int k = 0; k < 3; k++)
                    for (int s = 0; s < 4; s++) begin
                        logic [DW-1:0] p;
                        p = next_pat();
                        do_write(s[1:0], ~(s == 0 ? {2'b00, 13'd0} : 15'd0) & p);
                    end
                // R2/R3: second attempt at the level is ignored
                do_write(2'd0, {~lvl[1:0], next_pat()[12:0]});
                chk("R3 level unchanged after reseal attempt", {30'd0, lock_lvl}, lvl);
                // direction change after sealing: flipped channels follow
                ch_is_out = ~dir[1:0];
                do_write(2'd2, next_pat());
                do_write(2'd3, next_pat());
            end
        end

        // R10: mixed write at level 1
        ch_is_out = 2'b11;
        do_reset();
        do_write(2'd0, {2'd1, 13'h0000});
        do_write(2'd0, {2'd2, 13'h1FFF});
        chk("R10 open ofs updated", {30'd0, ofs_run, ofs_idle}, 32'd3);
        chk("R10 frozen dt kept", {24'd0, dt_code}, 32'd0);
        chk("R10 frozen break kept", {29'd0, auto_oe, brk_pol, brk_en}, 32'd0);

        // R3: sealing at level 0 blocks a later raise
        do_reset();
        do_write(2'd0, {2'd0, 13'h0055});
        do_write(2'd0, {2'd3, 13'h00AA});
        chk("R3 level stays 0", {30'd0, lock_lvl}, 32'd0);
        chk("R3 dt still open", {24'd0, dt_code}, 32'h0AA);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule